// File: doc/BRIEF.md
# Machine-Check Bank Logger

This block keeps a small array of machine-check reporting banks plus a global status word and a global control word. Hardware error sources present error events on a valid/ready stream. Each event names a bank, carries a 64-bit status word, a global status value, an address and a miscellaneous word. The block decides in one cycle whether to drop, log, merge or escalate the event. It then updates the chosen bank.

An uncorrected error that is logged raises a level interrupt. That interrupt stays high until it is acknowledged. An uncorrected error that arrives while an earlier one is still being handled, or while machine-check reporting is disabled, produces a shutdown pulse and logs nothing. Corrected errors never displace a valid uncorrected entry.

Bank and global contents are read through a simple combinational read port. The control words, and the global status, are written through a plain write port. Event back-pressure is trivial: `ev_ready` is low only during reset and the cycle that follows it. After that, every event presented with `ev_valid` is consumed on the clock edge where it is seen.

Top module: `mce_bank_logger`

## Requirements
- R1: An event is ignored when its bank index is not below both the low 8 bits of `cap` and the `NBANK` parameter, or when status bit 63 (valid) is clear. An ignored event changes no bank, no interrupt and no shutdown.
- R2: An uncorrected event (status bit 61 set) is dropped when `cap` bit 8 is set and the global control word is not all ones. When `cap` bit 8 is clear, the global control word has no effect.
- R3: An uncorrected event is dropped when the control word of its bank is not all ones. Corrected events ignore the bank control word.
- R4: An uncorrected event that passes R2 and R3 while global status bit 2 (in progress) is set, or while `mce_en` is low, logs nothing and drives `shutdown` high for exactly the next cycle.
- R5: An uncorrected event that otherwise passes writes the bank's status, address and misc words. It also loads the global status from `ev_gstat` and sets `irq`, all visible in the cycle after acceptance.
- R6: When a logged event finds its bank's stored status valid, the stored status becomes the new status with bit 62 (overflow) set.
- R7: A corrected event logs into a bank whose stored status is invalid or corrected. It leaves `irq` and the global status untouched.
- R8: A corrected event aimed at a bank holding a valid uncorrected status only sets bit 62 of that status. Address and misc are kept.
- R9: `irq` stays high until a cycle with `irq_ack` high clears it. A new interrupt in the same cycle as an acknowledge leaves `irq` high.
- R10: Reset sets the global control word and every bank control word to all ones. It clears the global status, all bank status, address and misc words, and `irq` and `shutdown`.
- R11: A write with `ctl_we` targets the control word of bank `ctl_sel` when `ctl_sel` < `NBANK`. It targets the global control word when `ctl_sel` = `NBANK`, and the global status when `ctl_sel` = `NBANK`+1. A global status load from R5 in the same cycle wins over the write.
- R12: `ev_ready` is low in reset and high from the second cycle after reset release onward. An event is accepted only when `ev_valid` and `ev_ready` are both high.
- R13: `rd_data` combinationally returns the word of bank `rd_bank` selected by `rd_sel`: 0 control, 1 status, 2 address, 3 misc. It returns zero when `rd_bank` is not below `NBANK`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap | input | 64 | Capability word: bank count in bits 7:0, global-control-present in bit 8 |
| mce_en | input | 1 | Machine-check reporting enable |
| ev_valid | input | 1 | Error event valid |
| ev_ready | output | 1 | Event accepted when high with `ev_valid` |
| ev_bank | input | 8 | Target bank index |
| ev_status | input | 64 | Event status word |
| ev_gstat | input | 64 | Global status to load on an uncorrected log |
| ev_addr | input | 64 | Error address |
| ev_misc | input | 64 | Miscellaneous error information |
| ctl_we | input | 1 | Control/global-status write enable |
| ctl_sel | input | $clog2(NBANK+2) | Write target select |
| ctl_wdata | input | 64 | Write data |
| rd_bank | input | 8 | Read bank index |
| rd_sel | input | 2 | Read word select |
| rd_data | output | 64 | Read data |
| gstat_o | output | 64 | Global status word |
| irq | output | 1 | Machine-check interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| shutdown | output | 1 | One-cycle shutdown request |

## Verification
Every cycle, the assertions check several properties. A shutdown pulse or a rising interrupt must trace back to an accepted, valid, uncorrected event. The two never appear together. The interrupt only falls after an acknowledge. Events without the valid bit stay silent. Any change of the global status must follow an accepted event or a write. The gating rules on both control words, the overflow merging, and the corrected-versus-uncorrected precedence depend on stored bank contents. They are shown only by the bench's scenarios, checked against its reference model and hand-computed bank values.

// File: rtl/mcelog_pkg.sv
package mcelog_pkg;
  localparam int WORD      = 64;
  localparam int ST_VAL    = 63;
  localparam int ST_OVF    = 62;
  localparam int ST_UNC    = 61;
  localparam int CAP_GP    = 8;
  localparam int GS_INPROG = 2;

  typedef logic [WORD-1:0] word_t;

  localparam word_t OVF_MASK = word_t'(1) << ST_OVF;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HALT,
    ACT_UNC,
    ACT_COR,
    ACT_MARK
  } act_e;
endpackage

// File: rtl/mcelog_gate.sv
module mcelog_gate
  import mcelog_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic       fire,
  input  logic [7:0] bank,
  input  logic [7:0] cap_cnt,
  input  logic       cap_gp,
  input  word_t      ev_status,
  input  word_t      gctl,
  input  word_t      bctl,
  input  word_t      bstat,
  input  word_t      gstat,
  input  logic       mce_en,
  output act_e       act
);
  localparam logic [7:0] NB8 = 8'(NBANK);

  logic in_range;
  assign in_range = (bank < cap_cnt) && (bank < NB8);

  always_comb begin
    act = ACT_NONE;
    if (fire && in_range && ev_status[ST_VAL]) begin
      if (ev_status[ST_UNC]) begin
        if (cap_gp && (gctl != '1))                 act = ACT_NONE;
        else if (bctl != '1)                        act = ACT_NONE;
        else if (gstat[GS_INPROG] || !mce_en)       act = ACT_HALT;
        else                                        act = ACT_UNC;
      end else if (bstat[ST_VAL] && bstat[ST_UNC]) begin
        act = ACT_MARK;
      end else begin
        act = ACT_COR;
      end
    end
  end
endmodule

// File: rtl/mcelog_bank.sv
module mcelog_bank
  import mcelog_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  word_t ctl_wdata,
  input  logic  log_en,
  input  logic  mark_en,
  input  word_t new_status,
  input  word_t new_addr,
  input  word_t new_misc,
  output word_t ctl_q,
  output word_t status_q,
  output word_t addr_q,
  output word_t misc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '1;
      status_q <= '0;
      addr_q   <= '0;
      misc_q   <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (log_en) begin
        status_q <= new_status | (status_q[ST_VAL] ? OVF_MASK : '0);
        addr_q   <= new_addr;
        misc_q   <= new_misc;
      end else if (mark_en) begin
        status_q[ST_OVF] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
  import mcelog_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int SW   = $clog2(NBANK + 2),
  localparam int BIW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   cap,
  input  logic          mce_en,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [7:0]    ev_bank,
  input  logic [63:0]   ev_status,
  input  logic [63:0]   ev_gstat,
  input  logic [63:0]   ev_addr,
  input  logic [63:0]   ev_misc,
  input  logic          ctl_we,
  input  logic [SW-1:0] ctl_sel,
  input  logic [63:0]   ctl_wdata,
  input  logic [7:0]    rd_bank,
  input  logic [1:0]    rd_sel,
  output logic [63:0]   rd_data,
  output logic [63:0]   gstat_o,
  output logic          irq,
  input  logic          irq_ack,
  output logic          shutdown
);
  localparam logic [7:0]    NB8      = 8'(NBANK);
  localparam logic [SW-1:0] SEL_GCTL = SW'(NBANK);
  localparam logic [SW-1:0] SEL_GST  = SW'(NBANK + 1);

  word_t b_ctl [NBANK];
  word_t b_st  [NBANK];
  word_t b_ad  [NBANK];
  word_t b_mi  [NBANK];

  word_t gctl_q, gstat_q;
  logic  rdy_q;
  act_e  act;

  logic           ev_fire, ev_in_arr, rd_in_arr;
  logic [BIW-1:0] ev_idx, rd_idx;
  word_t          sel_ctl, sel_st;

  assign ev_fire   = ev_valid && rdy_q;
  assign ev_in_arr = ev_bank < NB8;
  assign rd_in_arr = rd_bank < NB8;
  assign ev_idx    = ev_bank[BIW-1:0];
  assign rd_idx    = rd_bank[BIW-1:0];
  assign sel_ctl   = ev_in_arr ? b_ctl[ev_idx] : '1;
  assign sel_st    = ev_in_arr ? b_st[ev_idx]  : '0;

  mcelog_gate #(.NBANK(NBANK)) u_gate (
    .fire      (ev_fire),
    .bank      (ev_bank),
    .cap_cnt   (cap[7:0]),
    .cap_gp    (cap[CAP_GP]),
    .ev_status (ev_status),
    .gctl      (gctl_q),
    .bctl      (sel_ctl),
    .bstat     (sel_st),
    .gstat     (gstat_q),
    .mce_en    (mce_en),
    .act       (act)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = (ev_bank == 8'(i));
    mcelog_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we && (ctl_sel == SW'(i))),
      .ctl_wdata  (ctl_wdata),
      .log_en     (hit && ((act == ACT_UNC) || (act == ACT_COR))),
      .mark_en    (hit && (act == ACT_MARK)),
      .new_status (ev_status),
      .new_addr   (ev_addr),
      .new_misc   (ev_misc),
      .ctl_q      (b_ctl[i]),
      .status_q   (b_st[i]),
      .addr_q     (b_ad[i]),
      .misc_q     (b_mi[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      gctl_q   <= '1;
      gstat_q  <= '0;
      irq      <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      rdy_q    <= 1'b1;
      shutdown <= (act == ACT_HALT);
      if (ctl_we && (ctl_sel == SEL_GCTL)) gctl_q <= ctl_wdata;
      if (act == ACT_UNC)                         gstat_q <= ev_gstat;
      else if (ctl_we && (ctl_sel == SEL_GST))    gstat_q <= ctl_wdata;
      if (act == ACT_UNC) irq <= 1'b1;
      else if (irq_ack)   irq <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_in_arr) begin
      unique case (rd_sel)
        2'd0: rd_data = b_ctl[rd_idx];
        2'd1: rd_data = b_st[rd_idx];
        2'd2: rd_data = b_ad[rd_idx];
        2'd3: rd_data = b_mi[rd_idx];
      endcase
    end
  end

  assign ev_ready = rdy_q;
  assign gstat_o  = gstat_q;
endmodule

// File: rtl/mce_bank_logger_chk.sv
module mce_bank_logger_chk
  import mcelog_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ev_valid,
  input logic        ev_ready,
  input logic [63:0] ev_status,
  input logic        ctl_we,
  input logic [63:0] gstat_o,
  input logic        irq,
  input logic        irq_ack,
  input logic        shutdown
);
  // R4
  shut_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> $past(ev_valid && ev_ready && ev_status[ST_VAL] && ev_status[ST_UNC]));

  // R4
  shut_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !$rose(irq));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_valid && ev_ready && ev_status[ST_VAL] && ev_status[ST_UNC]));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_ack));

  // R1
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_status[ST_VAL]) |=> (!shutdown && !$rose(irq)));

  // R11
  gstat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gstat_o) |-> ($past(ev_valid && ev_ready) || $past(ctl_we)));
endmodule

bind mce_bank_logger mce_bank_logger_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_status (ev_status),
  .ctl_we    (ctl_we),
  .gstat_o   (gstat_o),
  .irq       (irq),
  .irq_ack   (irq_ack),
  .shutdown  (shutdown)
);

// File: tb/mce_bank_logger_bench.sv
`timescale 1ns/1ps
module mce_bank_logger_bench;
  localparam int NB = 4;
  localparam int SW = $clog2(NB + 2);
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] O = 64'h4000_0000_0000_0000;
  localparam logic [63:0] U = 64'h2000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cap = 64'h104;
  logic mce_en = 1'b1;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [7:0] ev_bank = '0;
  logic [63:0] ev_status = '0, ev_gstat = '0, ev_addr = '0, ev_misc = '0;
  logic ctl_we = 1'b0;
  logic [SW-1:0] ctl_sel = '0;
  logic [63:0] ctl_wdata = '0;
  logic [7:0] rd_bank = '0;
  logic [1:0] rd_sel = '0;
  logic [63:0] rd_data, gstat_o;
  logic irq, shutdown;
  logic irq_ack = 1'b0;

  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mce_bank_logger #(.NBANK(NB)) u_mce_bank_logger (
    .clk(clk), .rst_n(rst_n), .cap(cap), .mce_en(mce_en),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_bank(ev_bank),
    .ev_status(ev_status), .ev_gstat(ev_gstat), .ev_addr(ev_addr), .ev_misc(ev_misc),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data),
    .gstat_o(gstat_o), .irq(irq), .irq_ack(irq_ack), .shutdown(shutdown)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  logic [63:0] m_ctl [NB];
  logic [63:0] m_st [NB];
  logic [63:0] m_ad [NB];
  logic [63:0] m_mi [NB];
  logic [63:0] m_gctl, m_gst;
  logic m_irq, m_shut, m_rdy;

  function automatic logic [63:0] mread(logic [7:0] b, logic [1:0] s);
    if (b >= NB) return '0;
    case (s)
      2'd0: return m_ctl[b];
      2'd1: return m_st[b];
      2'd2: return m_ad[b];
      default: return m_mi[b];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_ctl[i] = '1; m_st[i] = '0; m_ad[i] = '0; m_mi[i] = '0;
      end
      m_gctl = '1; m_gst = '0; m_irq = 0; m_shut = 0; m_rdy = 0;
    end else begin
      int kind; // 0 none 1 halt 2 unc log 3 cor log 4 mark
      int cnt;
      kind = 0;
      cnt = (int'(cap[7:0]) < NB) ? int'(cap[7:0]) : NB;
      if (ev_valid && m_rdy && int'(ev_bank) < cnt && ev_status[63]) begin
        if (ev_status[61]) begin
          if (cap[8] && m_gctl != '1) kind = 0;
          else if (m_ctl[ev_bank] != '1) kind = 0;
          else if (m_gst[2] || !mce_en) kind = 1;
          else kind = 2;
        end else if (m_st[ev_bank][63] && m_st[ev_bank][61]) kind = 4;
        else kind = 3;
      end
      if (ctl_we) begin
        if (int'(ctl_sel) < NB) m_ctl[ctl_sel] = ctl_wdata;
        else if (int'(ctl_sel) == NB) m_gctl = ctl_wdata;
        else if (int'(ctl_sel) == NB + 1) m_gst = ctl_wdata;
      end
      if (kind == 2 || kind == 3) begin
        m_st[ev_bank] = ev_status | (m_st[ev_bank][63] ? O : 64'd0);
        m_ad[ev_bank] = ev_addr;
        m_mi[ev_bank] = ev_misc;
      end
      if (kind == 4) m_st[ev_bank] = m_st[ev_bank] | O;
      if (kind == 2) m_gst = ev_gstat;
      if (kind == 2) m_irq = 1;
      else if (irq_ack) m_irq = 0;
      m_shut = (kind == 1);
      m_rdy = 1;
    end
    #1;
    chk("R12 ready", {63'd0, ev_ready}, {63'd0, m_rdy});
    chk("R9 irq", {63'd0, irq}, {63'd0, m_irq});
    chk("R4 shutdown", {63'd0, shutdown}, {63'd0, m_shut});
    chk("R5 gstat", gstat_o, m_gst);
    chk("R13 rd_data", rd_data, mread(rd_bank, rd_sel));
  end

  task automatic send(logic [7:0] b, logic [63:0] st, logic [63:0] gs,
                      logic [63:0] ad, logic [63:0] mi);
    @(negedge clk);
    ev_bank = b; ev_status = st; ev_gstat = gs; ev_addr = ad; ev_misc = mi;
    ev_valid = 1;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic wctl(int sel, logic [63:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_sel = SW'(sel); ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic peek(logic [7:0] b, logic [1:0] s, logic [63:0] exp, string tag);
    rd_bank = b; rd_sel = s;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 irq", {63'd0, irq}, 64'd0);
    chk("R10 shutdown", {63'd0, shutdown}, 64'd0);
    chk("R10 gstat", gstat_o, 64'd0);
    peek(0, 0, '1, "R10 bank ctl");
    peek(2, 1, 64'd0, "R10 bank status");
    @(negedge clk);
    chk("R12 ready high", {63'd0, ev_ready}, 64'd1);

    // R5 uncorrected log
    send(1, V | U | 64'h11, 64'h5, 64'hA1, 64'hB1);
    chk("R5 irq", {63'd0, irq}, 64'd1);
    chk("R5 gstat", gstat_o, 64'h5);
    peek(1, 1, V | U | 64'h11, "R5 status");
    peek(1, 2, 64'hA1, "R5 addr");
    peek(1, 3, 64'hB1, "R5 misc");

    // R4 in-progress shutdown
    send(1, V | U | 64'h22, 64'h0, 64'hA9, 64'hB9);
    chk("R4 shutdown", {63'd0, shutdown}, 64'd1);
    peek(1, 1, V | U | 64'h11, "R4 no log");
    @(negedge clk);
    chk("R4 pulse", {63'd0, shutdown}, 64'd0);

    // R9 acknowledge
    ack();
    chk("R9 ack clears", {63'd0, irq}, 64'd0);

    // R11 global status write
    wctl(NB + 1, 64'h0);
    chk("R11 gstat write", gstat_o, 64'h0);

    // R7 corrected into empty bank
    send(2, V | 64'h33, 64'h7, 64'hA2, 64'hB2);
    peek(2, 1, V | 64'h33, "R7 status");
    chk("R7 no irq", {63'd0, irq}, 64'd0);
    chk("R7 gstat kept", gstat_o, 64'h0);
    // R6 corrected over corrected
    send(2, V | 64'h44, 64'h0, 64'hA3, 64'hB3);
    peek(2, 1, V | O | 64'h44, "R6 ce overflow");
    peek(2, 2, 64'hA3, "R6 ce addr");
    // R8 corrected over uncorrected
    send(1, V | 64'h55, 64'h0, 64'hA4, 64'hB4);
    peek(1, 1, V | U | O | 64'h11, "R8 mark only");
    peek(1, 2, 64'hA1, "R8 addr kept");
    // R6 uncorrected over valid
    send(1, V | U | 64'h66, 64'h1, 64'hA5, 64'hB5);
    peek(1, 1, V | U | O | 64'h66, "R6 uc overflow");
    chk("R6 irq", {63'd0, irq}, 64'd1);
    chk("R5 gstat load", gstat_o, 64'h1);
    ack();

    // R1 ignore rules
    cap = 64'h102;
    send(3, V | 64'h77, 64'h0, 64'hA7, 64'hB7);
    peek(3, 1, 64'd0, "R1 above cap count");
    send(2, 64'h88, 64'h0, 64'hA8, 64'hB8);
    peek(2, 1, V | O | 64'h44, "R1 no valid bit");
    cap = 64'h110;
    send(4, V | U | 64'h1, 64'h0, 64'h0, 64'h0);
    chk("R1 beyond array", {63'd0, irq}, 64'd0);
    cap = 64'h104;

    // R2 global control gating
    wctl(NB, 64'h0);
    send(0, V | U | 64'h99, 64'h0, 64'hA6, 64'hB6);
    chk("R2 dropped irq", {63'd0, irq}, 64'd0);
    peek(0, 1, 64'd0, "R2 dropped");
    cap = 64'h004;
    send(0, V | U | 64'h99, 64'h0, 64'hA6, 64'hB6);
    chk("R2 not present irq", {63'd0, irq}, 64'd1);
    peek(0, 1, V | U | 64'h99, "R2 not present log");
    ack();
    wctl(NB, '1);
    cap = 64'h104;

    // R3 bank control gating
    wctl(3, 64'h0);
    peek(3, 0, 64'h0, "R11 bank ctl write");
    send(3, V | U | 64'hAA, 64'h0, 64'h0, 64'h0);
    peek(3, 1, 64'd0, "R3 uc dropped");
    chk("R3 no irq", {63'd0, irq}, 64'd0);
    send(3, V | 64'hBB, 64'h0, 64'hAB, 64'hBB);
    peek(3, 1, V | 64'hBB, "R3 ce logged");

    // R4 reporting disabled
    mce_en = 0;
    send(2, V | U | 64'hCC, 64'h0, 64'h0, 64'h0);
    chk("R4 disabled shutdown", {63'd0, shutdown}, 64'd1);
    chk("R4 disabled no irq", {63'd0, irq}, 64'd0);
    mce_en = 1;

    // R9 set wins over ack
    @(negedge clk);
    ev_bank = 0; ev_status = V | U | 64'hDD; ev_gstat = 64'h0;
    ev_addr = 64'hAD; ev_misc = 64'hBD; ev_valid = 1; irq_ack = 1;
    @(negedge clk);
    ev_valid = 0; irq_ack = 0;
    chk("R9 set wins", {63'd0, irq}, 64'd1);
    peek(0, 1, V | U | O | 64'hDD, "R6 second uc");
    ack();

    // R11 event load wins over global status write
    @(negedge clk);
    ev_bank = 0; ev_status = V | U | 64'hEE; ev_gstat = 64'h3;
    ev_valid = 1; ctl_we = 1; ctl_sel = SW'(NB + 1); ctl_wdata = 64'hF0;
    @(negedge clk);
    ev_valid = 0; ctl_we = 0;
    chk("R11 event wins", gstat_o, 64'h3);

    // R13 out-of-range read
    peek(6, 1, 64'd0, "R13 out of range");
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule